// File: doc/BRIEF.md
# Interrupt Status and Enable Register

This block is one 16-bit host register of a network controller. It holds two sticky interrupt flags: a system-error flag, raised when a bus-master transfer ends in a data parity error, a master abort or a target abort, and an excessive-deferral flag, raised by the transmitter. Each flag has its own enable. The register also holds two controls that decide whether a finished transmit raises the transmit interrupt flag.

The host writes the whole register through a one-cycle write strobe. The enables and the transmit controls take the written value. The two flags are cleared by writing a one to them. Event inputs are one-cycle pulses. A transmit completion comes with a success flag and with the descriptor's last-transmit-interrupt bit. The block answers it in the same cycle with a pulse on `tx_int_set`, which the transmit interrupt flag elsewhere in the controller uses. The interrupt request line is the OR of the two enabled flags. It does not depend on any global interrupt enable.

Hard reset clears everything. Soft reset clears only the system-error flag, its enable and the two transmit controls. The deferral pair keeps its value across a soft reset.

Top module: `irq_status_reg`

## Requirements
- R1: Read layout: bit 15 is the OK-suppress control, bit 14 the per-descriptor override enable, bit 11 the system-error flag, bit 10 its enable, bit 7 the deferral flag and bit 6 its enable. Every other bit reads 0. A write loads bits 15, 14, 10 and 6 from the write data.
- R2: The system-error flag becomes 1 in the cycle after a pulse on `par_err`, `mst_abort` or `tgt_abort`.
- R3: Writing 1 to bit 11 or bit 7 clears that flag. Writing 0 to it leaves the flag unchanged.
- R4: If a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up 1.
- R5: A soft reset pulse clears bits 15, 14, 11 and 10, and leaves bits 7 and 6 unchanged.
- R6: Hard reset (`rst_n` low) clears every bit of the register.
- R7: `irq` is 1 exactly when (bit 11 AND bit 10) OR (bit 7 AND bit 6).
- R8: The deferral flag becomes 1 in the cycle after a pulse on `exc_defer`.
- R9: With bit 14 = 0, a transmit completion pulses `tx_int_set` in the same cycle if the transmit failed, or if it succeeded and bit 15 = 0.
- R10: With bit 14 = 1, bit 15 is ignored. A completion with `tx_lti` = 1 always pulses `tx_int_set`. With `tx_lti` = 0, only a failed transmit pulses it.
- R11: `tx_int_set` is 0 in every cycle where `tx_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset pulse, synchronous |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Register read value |
| par_err | input | 1 | Bus data parity error pulse |
| mst_abort | input | 1 | Bus master abort pulse |
| tgt_abort | input | 1 | Bus target abort pulse |
| exc_defer | input | 1 | Excessive deferral pulse |
| tx_done | input | 1 | Transmit completion pulse |
| tx_ok | input | 1 | Transmit succeeded (valid with tx_done) |
| tx_lti | input | 1 | Descriptor last-transmit-interrupt bit (valid with tx_done) |
| tx_int_set | output | 1 | Pulse that sets the transmit interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle: the request line against the flag and enable bits read back, the flags setting after their events, soft reset clearing its four bits, a zero write keeping the system-error flag, the descriptor override forcing the transmit pulse, and reserved bits staying zero. Other behaviour only shows in the bench scenarios. These are the full transmit qualification matrix across both controls, a set and a clear landing on the same flag in the same cycle, the deferral pair surviving a soft reset, and a hard reset in the middle of random traffic.

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W        = 16,
  parameter int TOKD_BIT = 15,
  parameter int LTE_BIT  = 14,
  parameter int SYS_BIT  = 11,
  parameter int SYSE_BIT = 10,
  parameter int EXD_BIT  = 7,
  parameter int EXDE_BIT = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         par_err,
  input  logic         mst_abort,
  input  logic         tgt_abort,
  input  logic         exc_defer,
  input  logic         tx_done,
  input  logic         tx_ok,
  input  logic         tx_lti,
  output logic         tx_int_set,
  output logic         irq
);
  localparam logic [W-1:0] USED_MASK =
    (W'(1) << TOKD_BIT) | (W'(1) << LTE_BIT) | (W'(1) << SYS_BIT) |
    (W'(1) << SYSE_BIT) | (W'(1) << EXD_BIT) | (W'(1) << EXDE_BIT);

  logic tokd, lte, sys, syse, exd, exde;
  logic sys_evt;
  logic unused_wr;

  assign sys_evt   = par_err | mst_abort | tgt_abort;
  assign unused_wr = ^(wr_data & ~USED_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tokd <= 1'b0;
      lte  <= 1'b0;
      sys  <= 1'b0;
      syse <= 1'b0;
    end else if (soft_rst) begin
      tokd <= 1'b0;
      lte  <= 1'b0;
      sys  <= 1'b0;
      syse <= 1'b0;
    end else begin
      if (wr_en) begin
        tokd <= wr_data[TOKD_BIT];
        lte  <= wr_data[LTE_BIT];
        syse <= wr_data[SYSE_BIT];
      end
      if (sys_evt)
        sys <= 1'b1;
      else if (wr_en && wr_data[SYS_BIT])
        sys <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exd  <= 1'b0;
      exde <= 1'b0;
    end else begin
      if (wr_en)
        exde <= wr_data[EXDE_BIT];
      if (exc_defer)
        exd <= 1'b1;
      else if (wr_en && wr_data[EXD_BIT])
        exd <= 1'b0;
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[TOKD_BIT] = tokd;
    rd_data[LTE_BIT]  = lte;
    rd_data[SYS_BIT]  = sys;
    rd_data[SYSE_BIT] = syse;
    rd_data[EXD_BIT]  = exd;
    rd_data[EXDE_BIT] = exde;
  end

  assign tx_int_set = tx_done & (lte ? (tx_lti | ~tx_ok) : (~tokd | ~tx_ok));
  assign irq        = (sys & syse) | (exd & exde);
endmodule

module irq_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        par_err,
  input logic        mst_abort,
  input logic        tgt_abort,
  input logic        exc_defer,
  input logic        tx_done,
  input logic        tx_lti,
  input logic        tx_int_set,
  input logic        irq
);
  // R7
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((rd_data[11] & rd_data[10]) | (rd_data[7] & rd_data[6])));
  // R2
  sys_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err || mst_abort || tgt_abort) && !soft_rst |=> rd_data[11]);
  // R8
  exd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_defer |=> rd_data[7]);
  // R5
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rd_data[15:14] == 2'b00) && (rd_data[11:10] == 2'b00));
  // R3
  zero_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[11] && wr_en && !wr_data[11] && !soft_rst |=> rd_data[11]);
  // R10
  lti_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && tx_lti && rd_data[14] |-> tx_int_set);
  // R11
  no_done_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_done |-> !tx_int_set);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[13:12] == 2'b00 && rd_data[9:8] == 2'b00 && rd_data[5:0] == 6'd0);
endmodule

bind irq_status_reg irq_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .par_err(par_err),
  .mst_abort(mst_abort), .tgt_abort(tgt_abort), .exc_defer(exc_defer),
  .tx_done(tx_done), .tx_lti(tx_lti), .tx_int_set(tx_int_set), .irq(irq)
);

// File: tb/tb_irq_status_reg.sv
`timescale 1ns/1ps
module tb_irq_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic par_err = 1'b0, mst_abort = 1'b0, tgt_abort = 1'b0, exc_defer = 1'b0;
  logic tx_done = 1'b0, tx_ok = 1'b0, tx_lti = 1'b0;
  logic tx_int_set, irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic m_tokd, m_lte, m_sys, m_syse, m_exd, m_exde;

  always #2.5 clk = ~clk;

  irq_status_reg dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .par_err(par_err),
    .mst_abort(mst_abort), .tgt_abort(tgt_abort), .exc_defer(exc_defer),
    .tx_done(tx_done), .tx_ok(tx_ok), .tx_lti(tx_lti),
    .tx_int_set(tx_int_set), .irq(irq));

  function automatic logic [15:0] exp_rd();
    logic [15:0] v = '0;
    v[15] = m_tokd; v[14] = m_lte; v[11] = m_sys;
    v[10] = m_syse; v[7] = m_exd; v[6] = m_exde;
    return v;
  endfunction

  function automatic logic exp_tx(logic td, logic ok, logic lti);
    if (!td) return 1'b0;
    if (m_lte) return lti | ~ok;
    return ~m_tokd | ~ok;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    {m_tokd, m_lte, m_sys, m_syse, m_exd, m_exde} = '0;
  endtask

  task automatic step(logic we, logic [15:0] wd, logic sr, logic [2:0] err,
                      logic ex, logic td, logic ok, logic lti);
    logic e_tx;
    @(negedge clk);
    wr_en = we; wr_data = wd; soft_rst = sr;
    {par_err, mst_abort, tgt_abort} = err; exc_defer = ex;
    tx_done = td; tx_ok = ok; tx_lti = lti;
    #1;
    e_tx = exp_tx(td, ok, lti);
    chk("R1", rd_data, exp_rd());
    chk("R7", {15'd0, irq}, {15'd0, (m_sys & m_syse) | (m_exd & m_exde)});
    if (!td)        chk("R11", {15'd0, tx_int_set}, {15'd0, e_tx});
    else if (m_lte) chk("R10", {15'd0, tx_int_set}, {15'd0, e_tx});
    else            chk("R9",  {15'd0, tx_int_set}, {15'd0, e_tx});
    @(posedge clk);
    if (sr) begin
      m_tokd = 0; m_lte = 0; m_sys = 0; m_syse = 0;
    end else begin
      if (we) begin m_tokd = wd[15]; m_lte = wd[14]; m_syse = wd[10]; end
      if (|err) m_sys = 1; else if (we && wd[11]) m_sys = 0;
    end
    if (we) m_exde = wd[6];
    if (ex) m_exd = 1; else if (we && wd[7]) m_exd = 0;
  endtask

  task automatic idle();
    step(0, '0, 0, 3'b000, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    chk("R6", rd_data, 16'h0000);
    chk("R7", {15'd0, irq}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    step(1, 16'hC440, 0, 3'b000, 0, 0, 0, 0);
    idle(); chk("R1", rd_data, 16'hC440);

    for (int k = 0; k < 3; k++) begin
      step(0, '0, 0, 3'b100 >> k, 0, 0, 0, 0);
      idle(); chk("R2", {15'd0, rd_data[11]}, 16'h1);
      chk("R7", {15'd0, irq}, 16'h1);
      step(1, 16'h0400, 0, 3'b000, 0, 0, 0, 0);
      idle(); chk("R3", {15'd0, rd_data[11]}, 16'h1);
      step(1, 16'h0C00, 0, 3'b000, 0, 0, 0, 0);
      idle(); chk("R3", {15'd0, rd_data[11]}, 16'h0);
    end

    step(0, '0, 0, 3'b010, 1, 0, 0, 0);
    step(1, 16'h0C80, 0, 3'b001, 1, 0, 0, 0);
    idle();
    chk("R4", {15'd0, rd_data[11]}, 16'h1);
    chk("R4", {15'd0, rd_data[7]}, 16'h1);

    step(1, 16'h0040, 0, 3'b000, 0, 0, 0, 0);
    idle(); chk("R8", {15'd0, rd_data[7]}, 16'h1);
    chk("R3", {15'd0, rd_data[11]}, 16'h1);
    step(1, 16'hC440, 0, 3'b000, 0, 0, 0, 0);
    step(0, '0, 1, 3'b000, 0, 0, 0, 0);
    idle(); chk("R5", rd_data, 16'h00C0);
    chk("R7", {15'd0, irq}, 16'h1);

    for (int c = 0; c < 16; c++) begin
      step(1, {c[1], c[0], 14'd0}, 0, 3'b000, 0, 0, 0, 0);
      step(0, '0, 0, 3'b000, 0, 1, c[2], c[3]);
    end

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] wd = $urandom() & 16'hCCC0;
      step(($urandom() % 4) == 0, wd, ($urandom() % 32) == 0,
           {($urandom() % 16) == 0, ($urandom() % 16) == 0, ($urandom() % 16) == 0},
           ($urandom() % 16) == 0, ($urandom() % 3) == 0,
           1'($urandom()), 1'($urandom()));
      if (i == 1500) begin
        @(negedge clk); rst_n = 1'b0; #1;
        model_clear();
        chk("R6", rd_data, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule